// File: doc/BRIEF.md
# Mixed-Decay PWM Current Chopper

This block drives one H-bridge of a bipolar stepper winding so that the winding current follows a commanded level. Time is cut into chopping periods of five sub-cycles, each sub-cycle a fixed number of master-clock cycles. Every period opens in charge. A rise of the current-sense comparator moves the bridge into slow decay. The last two sub-cycles are always fast decay, so fast decay always holds 40% of the period. When the comparator still shows the current above target at the close of a period, the next period applies only a short sensing charge pulse and then regulates with slow and fast decay alone.

A direction bit chooses the sign of the current, and so the diagonal of the bridge used for charge and fast decay. That bit is captured only at the start of a period. Every change of bridge state passes through a dead-time window in which only the gates common to the old and new patterns stay on. Dropping enable turns all four gates off at once and holds the period timer at its start. The comparator input is asynchronous and goes through a two-flop synchronizer. A phase indicator reports which decay phase the controller is commanding.

Top module: `mixed_decay_chopper`

## Requirements
- R1: With default parameters a chopping period is 100 master-clock cycles: five sub-cycles of 20 cycles each. Counting cycles from reset release or from enable rising (cycle 0), charge is commanded at cycles 0, 100, 200 and so on, and the period position returns to 0 after cycle 99.
- R2: phase_o reads 3 (fast decay) from period position 60 through 99, which are the last two sub-cycles. It never reads fast decay before position 60. Fast decay is followed only by fast decay or by the charge of the next period.
- R3: In a normal period, cmp_in driven high in cycle c gives phase_o = 2 (slow decay) from cycle c+3, after two synchronizer stages and one state register. Slow decay then lasts until position 60 and does not return to charge within the period.
- R4: If the comparator never trips in a normal period, phase_o goes straight from 1 (charge) at position 59 to 3 (fast) at position 60.
- R5: If the synchronized comparator is high at position 99, the next period commands charge for SENSE_CYC = 4 cycles only (positions 0 to 3) and slow decay from position 4, whatever the comparator does during that period.
- R6: Gates are read as {U1,U2,L1,L2}. With dir_in = 0, charge is 1001, slow decay is 0011 and fast decay is 0110. With dir_in = 1, charge is 0110, slow decay is 0011 and fast decay is 1001.
- R7: On every change of commanded pattern, the gates that must turn off do so first. Only the gates shared by both patterns stay on for DEAD_CYC cycles (2 at defaults: 300 ns over a 250 ns master clock, rounded up). The new pattern appears DEAD_CYC+1 cycles after phase_o changes. No gate turns on in a cycle where another turns off, and U1 with L1 or U2 with L2 are never on together.
- R8: With en low, all four gates and phase_o read 0 in that same cycle. On en rising, the period restarts at position 0 in charge, with all gates off for the first DEAD_CYC+1 cycles.
- R9: In a normal period the comparator is ignored at position 0, so a flag seen only there does not end charge.
- R10: A change of dir_in mid-period leaves the patterns unchanged until the next period starts.
- R11: While rst is high, all four gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Bridge enable; low forces all gates off |
| dir_in | input | 1 | Sign of commanded current (0 positive, 1 negative) |
| cmp_in | input | 1 | Asynchronous comparator flag, high when sensed current reaches target |
| gate_u1_o | output | 1 | High-side gate, leg 1 |
| gate_u2_o | output | 1 | High-side gate, leg 2 |
| gate_l1_o | output | 1 | Low-side gate, leg 1 |
| gate_l2_o | output | 1 | Low-side gate, leg 2 |
| phase_o | output | 2 | Commanded phase: 0 off, 1 charge, 2 slow, 3 fast |

## Verification
Some properties are checked on every cycle: the absence of shoot-through on each leg, that no gate turns on in the cycle another turns off, that decay phases move only forward within a period, that the direction register changes only at a period boundary or while disabled, and that the internal gate register clears while disabled. Only the bench's scenarios can show the actual cycle counts. Those are the synchronizer latency to slow decay, the length of the sensing pulse in a skipped-charge period, blanking at the first position, the exact point where fast decay begins, and the delayed effect of a direction change. The bench also shows the same-cycle shutdown and restart on enable.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_CHARGE = 2'd1,
    PH_SLOW   = 2'd2,
    PH_FAST   = 2'd3
  } phase_e;

  // Gate word order is {U1,U2,L1,L2}; neg selects the reversed diagonal.
  function automatic logic [3:0] bridge_pattern(phase_e ph, logic neg);
    logic [3:0] diag_a;
    logic [3:0] diag_b;
    diag_a = 4'b1001;
    diag_b = 4'b0110;
    unique case (ph)
      PH_CHARGE: return neg ? diag_b : diag_a;
      PH_SLOW:   return 4'b0011;
      PH_FAST:   return neg ? diag_a : diag_b;
      default:   return 4'b0000;
    endcase
  endfunction

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
  parameter int unsigned DIV       = 20,
  parameter int unsigned SUBS      = 5,
  parameter int unsigned FAST_SUBS = 2,
  parameter int unsigned SENSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic at_start,
  output logic period_end,
  output logic fast_win,
  output logic sense_point
);
  localparam int unsigned DW = $clog2(DIV);
  localparam int unsigned SW = $clog2(SUBS);
  localparam logic [DW-1:0] DIV_LAST   = DW'(DIV - 1);
  localparam logic [SW-1:0] SUB_LAST   = SW'(SUBS - 1);
  localparam logic [SW-1:0] MDT_SUB    = SW'(SUBS - FAST_SUBS);
  localparam logic [DW-1:0] SENSE_LAST = DW'(SENSE_CYC - 1);

  logic [DW-1:0] div_cnt;
  logic [SW-1:0] sub_cnt;
  logic          sub_tick;

  assign sub_tick    = (div_cnt == DIV_LAST);
  assign period_end  = sub_tick && (sub_cnt == SUB_LAST);
  assign at_start    = (div_cnt == '0) && (sub_cnt == '0);
  assign fast_win    = (sub_cnt >= MDT_SUB);
  assign sense_point = (sub_cnt == '0) && (div_cnt == SENSE_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_cnt <= '0;
      sub_cnt <= '0;
    end else if (sub_tick) begin
      div_cnt <= '0;
      sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  p_period_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (en && period_end) |=> at_start);

endmodule

// File: rtl/chop_cmp_sync.sv
module chop_cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
  import chop_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   cmp_s,
  input  logic   dir_in,
  input  logic   at_start,
  input  logic   period_end,
  input  logic   fast_win,
  input  logic   sense_point,
  output phase_e phase,
  output logic   dir_q
);
  logic charge_q;
  logic skip_q;
  logic trip_evt;
  logic sense_end;

  // Comparator trip in a normal period, blanked on the first cycle.
  assign trip_evt  = !skip_q && cmp_s && !at_start;
  assign sense_end = skip_q && sense_point;

  always_ff @(posedge clk) begin
    if (rst) begin
      charge_q <= 1'b1;
      skip_q   <= 1'b0;
      dir_q    <= 1'b0;
    end else if (!en) begin
      charge_q <= 1'b1;
      skip_q   <= 1'b0;
      dir_q    <= dir_in;
    end else if (period_end) begin
      charge_q <= 1'b1;
      skip_q   <= cmp_s;
      dir_q    <= dir_in;
    end else if (charge_q && (trip_evt || sense_end)) begin
      charge_q <= 1'b0;
    end
  end

  always_comb begin
    if (!en)           phase = PH_OFF;
    else if (fast_win) phase = PH_FAST;
    else if (charge_q) phase = PH_CHARGE;
    else               phase = PH_SLOW;
  end

  p_fast_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_FAST) |=> (!en || phase == PH_FAST || phase == PH_CHARGE));

  p_slow_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_SLOW) |=> (!en || phase == PH_SLOW || phase == PH_FAST));

  p_dir_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $changed(dir_q) |-> $past(period_end || !en));

endmodule

// File: rtl/chop_deadtime.sv
module chop_deadtime #(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [3:0] des,
  output logic [3:0] gate_q
);
  localparam int unsigned TW = $clog2(DEAD_CYC + 1);
  localparam logic [TW-1:0] DEAD_LOAD = TW'(DEAD_CYC);
  localparam logic [TW-1:0] DEAD_ONE  = TW'(1);

  logic [TW-1:0] dt_cnt;
  logic          breaking;
  logic [3:0]    keep;

  assign keep     = gate_q & des;
  assign breaking = |(gate_q & ~des);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate_q <= '0;
      dt_cnt <= '0;
    end else if (dt_cnt == '0) begin
      if (des != gate_q) begin
        gate_q <= keep;
        dt_cnt <= DEAD_LOAD;
      end
    end else if (dt_cnt == DEAD_ONE) begin
      if (!breaking) begin
        gate_q <= des;
        dt_cnt <= '0;
      end else begin
        gate_q <= keep;
        dt_cnt <= DEAD_LOAD;
      end
    end else begin
      dt_cnt <= dt_cnt - 1'b1;
    end
  end

  p_no_shoot_r7: assert property (@(posedge clk) disable iff (rst)
    !((gate_q[3] && gate_q[1]) || (gate_q[2] && gate_q[0])));

  p_break_before_make_r7: assert property (@(posedge clk) disable iff (rst)
    ((gate_q & ~$past(gate_q)) != 4'b0000) |-> (($past(gate_q) & ~gate_q) == 4'b0000));

endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
  import chop_pkg::*;
#(
  parameter int unsigned MCLK_NS   = 250,
  parameter int unsigned DEAD_NS   = 300,
  parameter int unsigned DIV       = 20,
  parameter int unsigned SUBS      = 5,
  parameter int unsigned FAST_SUBS = 2,
  parameter int unsigned SENSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       dir_in,
  input  logic       cmp_in,
  output logic       gate_u1_o,
  output logic       gate_u2_o,
  output logic       gate_l1_o,
  output logic       gate_l2_o,
  output logic [1:0] phase_o
);
  localparam int unsigned DEAD_RAW = ceil_div(DEAD_NS, MCLK_NS);
  localparam int unsigned DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW;

  logic       at_start;
  logic       period_end;
  logic       fast_win;
  logic       sense_point;
  logic       cmp_s;
  logic       dir_q;
  phase_e     phase;
  logic [3:0] des;
  logic [3:0] gate_q;
  logic [3:0] gates;

  chop_timebase #(
    .DIV(DIV), .SUBS(SUBS), .FAST_SUBS(FAST_SUBS), .SENSE_CYC(SENSE_CYC)
  ) u_tb (
    .clk(clk), .rst(rst), .en(en),
    .at_start(at_start), .period_end(period_end),
    .fast_win(fast_win), .sense_point(sense_point)
  );

  chop_cmp_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(cmp_in), .sync_out(cmp_s)
  );

  chop_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .cmp_s(cmp_s), .dir_in(dir_in),
    .at_start(at_start), .period_end(period_end), .fast_win(fast_win),
    .sense_point(sense_point), .phase(phase), .dir_q(dir_q)
  );

  assign des = bridge_pattern(phase, dir_q);

  chop_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst(rst), .en(en), .des(des), .gate_q(gate_q)
  );

  // Enable acts on the outputs in the same cycle.
  assign gates     = gate_q & {4{en}};
  assign gate_u1_o = gates[3];
  assign gate_u2_o = gates[2];
  assign gate_l1_o = gates[1];
  assign gate_l2_o = gates[0];
  assign phase_o   = phase;

  p_dis_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_q == 4'b0000));

endmodule

// File: tb/mixed_decay_chopper_tb.sv
module mixed_decay_chopper_tb;
  localparam logic [1:0] P_OFF = 2'd0, P_CHG = 2'd1, P_SLW = 2'd2, P_FST = 2'd3;

  logic clk = 1'b0;
  logic rst, en, dir_in, cmp_in;
  logic u1, u2, l1, l2;
  logic [1:0] phase_o;

  always #4 clk = ~clk;

  mixed_decay_chopper u_dut (
    .clk(clk), .rst(rst), .en(en), .dir_in(dir_in), .cmp_in(cmp_in),
    .gate_u1_o(u1), .gate_u2_o(u2), .gate_l1_o(l1), .gate_l2_o(l2),
    .phase_o(phase_o)
  );

  typedef struct {
    int         at;
    bit         is_ph;
    logic [3:0] val;
    string      tag;
  } item_t;

  item_t sb[$];
  int    rel = -1000;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  function automatic logic [3:0] gates_now();
    return {u1, u2, l1, l2};
  endfunction

  task automatic exp_g(int at, logic [3:0] v, string tag);
    item_t it;
    it.at = at; it.is_ph = 1'b0; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_ph(int at, logic [1:0] v, string tag);
    item_t it;
    it.at = at; it.is_ph = 1'b1; it.val = {2'b00, v}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic adv_to(int target);
    while (rel < target) begin
      @(posedge clk);
      @(negedge clk);
      rel++;
    end
  endtask

  task automatic segment_drained(string tag);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected items left, expected 0", tag, sb.size());
      sb.delete();
    end
  endtask

  // Monitor: pops scoreboard items that fall due in the current cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == rel) begin
          logic [3:0] got;
          got = sb[i].is_ph ? {2'b00, phase_o} : gates_now();
          checks++;
          if (got !== sb[i].val) begin
            fails++;
            $display("FAIL %s cycle %0d %s: got %b expected %b", sb[i].tag, rel,
                     sb[i].is_ph ? "phase" : "gates", got, sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  // Driver
  initial begin
    rst = 1'b1; en = 1'b1; dir_in = 1'b0; cmp_in = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    checks++;
    if (gates_now() !== 4'b0000) begin
      fails++;
      $display("FAIL R11 reset: got %b expected 0000", gates_now());
    end

    // Segment A: release from reset.
    exp_ph(0, P_CHG, "R1");
    exp_g(2, 4'b0000, "R7");
    exp_g(3, 4'b1001, "R6");
    exp_g(23, 4'b1001, "R7");
    exp_ph(23, P_SLW, "R3");
    exp_g(24, 4'b0001, "R7");
    exp_g(26, 4'b0011, "R6");
    exp_ph(59, P_SLW, "R2");
    exp_ph(60, P_FST, "R2");
    exp_g(61, 4'b0010, "R7");
    exp_g(63, 4'b0110, "R6");
    exp_ph(99, P_FST, "R2");
    exp_ph(100, P_CHG, "R5");
    exp_g(101, 4'b0000, "R7");
    exp_g(103, 4'b1001, "R5");
    exp_ph(103, P_CHG, "R5");
    exp_ph(104, P_SLW, "R5");
    exp_g(107, 4'b0011, "R5");
    exp_g(163, 4'b0110, "R10");
    exp_ph(200, P_CHG, "R1");
    exp_g(201, 4'b0110, "R10");
    exp_g(203, 4'b0110, "R6");
    exp_ph(259, P_CHG, "R4");
    exp_ph(260, P_FST, "R4");
    exp_g(261, 4'b0000, "R7");
    exp_g(263, 4'b1001, "R6");
    exp_ph(301, P_CHG, "R9");
    exp_ph(302, P_CHG, "R9");
    exp_g(303, 4'b0110, "R9");
    exp_ph(323, P_SLW, "R3");
    exp_g(324, 4'b0010, "R7");
    exp_g(326, 4'b0011, "R6");
    exp_ph(350, P_OFF, "R8");
    exp_g(350, 4'b0000, "R8");
    exp_g(355, 4'b0000, "R8");

    @(negedge clk);
    rst = 1'b0;
    rel = 0;
    adv_to(20);  cmp_in = 1'b1;   // trip, held high through period end
    adv_to(110); cmp_in = 1'b0;
    adv_to(150); dir_in = 1'b1;   // mid-period direction change
    adv_to(298); cmp_in = 1'b1;   // seen only at position 0
    adv_to(299); cmp_in = 1'b0;
    adv_to(320); cmp_in = 1'b1;   // negative-direction trip
    adv_to(321); cmp_in = 1'b0;
    adv_to(350); en = 1'b0;
    adv_to(360);
    segment_drained("R8");

    // Segment B: restart on enable, negative direction.
    exp_ph(0, P_CHG, "R8");
    exp_g(2, 4'b0000, "R8");
    exp_g(3, 4'b0110, "R8");
    exp_ph(59, P_CHG, "R1");
    exp_ph(60, P_FST, "R1");
    exp_g(63, 4'b1001, "R6");
    exp_ph(100, P_CHG, "R1");
    en = 1'b1;
    rel = 0;
    adv_to(101);
    segment_drained("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule